// File: doc/BRIEF.md
# Two-Phase Handshake Serial Link

This block carries bytes across a single data wire between a sending side and a receiving side that share no clock and agree on no bit rate. A bit is announced by a change of level on a request wire, never by a pulse. The receiving side answers with a change of level on an acknowledge wire. Because the sender waits for that answer before it moves on, the link runs at whatever pace the slower side sets. It stays correct when the receiver stops answering for any length of time.

The sending side takes a byte through a valid/ready port in its own clock domain and shifts it out least significant bit first. For each bit it first sets the data wire, then toggles the request one cycle later. The receiving side passes the request through a synchroniser. When the synchronised request differs from its acknowledge, it captures the data wire and toggles the acknowledge. After the eighth bit it presents the byte on a valid/ready port in its own domain. It holds back further acknowledges until that byte has been taken. The acknowledge is synchronised on the sending side in the same way. Each side also gets a synchronous release of the shared active-low reset.

Top module: `hsl_link`

## Requirements
- R1: While reset is held and just after it, tx_ready is 1, rx_valid is 0, and line_req and line_ack are both 0.
- R2: The bits on line_data, sampled at successive changes of line_req, are bits 0 through 7 of the accepted byte, in that order (least significant first).
- R3: line_data does not change in the transmit clock cycle in which line_req changes; the data is set at least one cycle before the toggle.
- R4: line_req changes only when line_req equals line_ack, so at most one bit is outstanding.
- R5: line_ack changes only when line_req differs from line_ack.
- R6: Every byte accepted on tx_valid/tx_ready appears once on rx_data with rx_valid, in acceptance order.
- R7: Once rx_valid is 1, it stays 1 and rx_data stays unchanged until a cycle in which rx_ready is 1.
- R8: While rx_valid is 1 and rx_ready is 0, line_ack does not change, and the sender stays busy (tx_ready 0) with a further byte for as long as the stall lasts.
- R9: After a byte is accepted (tx_valid and tx_ready both 1 at a transmit clock edge), tx_ready is 0 in the next cycle and stays 0 until the eighth bit has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tx | input | 1 | Sending side clock |
| clk_rx | input | 1 | Receiving side clock, unrelated to clk_tx |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| tx_valid | input | 1 | A byte is offered on tx_data |
| tx_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | Sender idle; byte accepted when tx_valid is also 1 |
| rx_valid | output | 1 | A received byte is held on rx_data |
| rx_data | output | DATA_W | Received byte |
| rx_ready | input | 1 | Consumer takes the held byte |
| line_data | output | 1 | Serial data wire |
| line_req | output | 1 | Request wire, toggled once per bit |
| line_ack | output | 1 | Acknowledge wire, toggled once per captured bit |

## Verification
The assertions assume that tx_valid and tx_data change only between transmit clock edges. They also assume the consumer keeps rx_ready synchronous to clk_rx. The line wires are compared in the domain that drives them. So each property about a toggle reads the other side's wire raw, relying on the fact that a raw wire is never behind its synchronised copy. The bench drives all inputs on falling edges of their own clock. It randomises rx_ready for back-pressure and uses one long forced stall to exercise R8. The two clocks are unrelated (10 ns and 13 ns), so the handshake crosses in both directions at shifting phases.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SETUP = 2'd1,
    TX_WAIT  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hsl_tx.sv
module hsl_tx
  import hsl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              wire_data,
  output logic              wire_req,
  input  logic              wire_ack
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic rst_local_n, ack_s;
  tx_state_t st_q, st_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic data_q, data_n, req_q, req_n;

  hsl_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_local_n));
  hsl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_local_n), .d(wire_ack), .q(ack_s));

  always_comb begin
    st_n   = st_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    data_n = data_q;
    req_n  = req_q;
    case (st_q)
      TX_IDLE: begin
        if (in_valid) begin
          sh_n   = in_data;
          data_n = in_data[0];
          cnt_n  = '0;
          st_n   = TX_SETUP;
        end
      end
      TX_SETUP: begin
        req_n = ~req_q;
        st_n  = TX_WAIT;
      end
      TX_WAIT: begin
        if (ack_s == req_q) begin
          if (cnt_q == LAST) begin
            st_n = TX_IDLE;
          end else begin
            cnt_n  = cnt_q + 1'b1;
            sh_n   = sh_q >> 1;
            data_n = sh_q[1];
            st_n   = TX_SETUP;
          end
        end
      end
      default: st_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_local_n) begin
    if (!rst_local_n) begin
      st_q   <= TX_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      data_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      data_q <= data_n;
      req_q  <= req_n;
    end
  end

  assign in_ready  = (st_q == TX_IDLE);
  assign wire_data = data_q;
  assign wire_req  = req_q;
endmodule

// File: rtl/hsl_rx.sv
module hsl_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wire_data,
  input  logic              wire_req,
  output logic              wire_ack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic rst_local_n, req_s, take;
  logic ack_q, ack_n, full_q, full_n;
  logic [DATA_W-1:0] sh_q, sh_n, out_q, out_n, merged;
  logic [CW-1:0] cnt_q, cnt_n;

  hsl_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_local_n));
  hsl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_local_n), .d(wire_req), .q(req_s));

  assign take   = (req_s != ack_q) && !full_q;
  assign merged = {wire_data, sh_q[DATA_W-1:1]};

  always_comb begin
    ack_n  = ack_q;
    full_n = full_q;
    sh_n   = sh_q;
    out_n  = out_q;
    cnt_n  = cnt_q;
    if (full_q && out_ready) full_n = 1'b0;
    if (take) begin
      ack_n = ~ack_q;
      sh_n  = merged;
      if (cnt_q == LAST) begin
        cnt_n  = '0;
        out_n  = merged;
        full_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_local_n) begin
    if (!rst_local_n) begin
      ack_q  <= 1'b0;
      full_q <= 1'b0;
      sh_q   <= '0;
      out_q  <= '0;
      cnt_q  <= '0;
    end else begin
      ack_q  <= ack_n;
      full_q <= full_n;
      sh_q   <= sh_n;
      out_q  <= out_n;
      cnt_q  <= cnt_n;
    end
  end

  assign wire_ack  = ack_q;
  assign out_valid = full_q;
  assign out_data  = out_q;
endmodule

// File: rtl/hsl_link.sv
module hsl_link #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_tx,
  input  logic              clk_rx,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              line_data,
  output logic              line_req,
  output logic              line_ack
);
  hsl_tx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk_tx), .rst_n(rst_n),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .wire_data(line_data), .wire_req(line_req), .wire_ack(line_ack));

  hsl_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk_rx), .rst_n(rst_n),
    .wire_data(line_data), .wire_req(line_req), .wire_ack(line_ack),
    .out_valid(rx_valid), .out_data(rx_data), .out_ready(rx_ready));
endmodule

// File: rtl/hsl_link_chk.sv
module hsl_link_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_tx,
  input logic              clk_rx,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              line_data,
  input logic              line_req,
  input logic              line_ack
);
  // R3: data wire unchanged in the cycle the request toggles
  assert_data_stable_R3: assert property (@(posedge clk_tx) disable iff (!rst_n)
    (line_req != $past(line_req)) |-> (line_data == $past(line_data)));

  // R4: request toggles only with no bit outstanding
  assert_one_outstanding_R4: assert property (@(posedge clk_tx) disable iff (!rst_n)
    (line_req != $past(line_req)) |-> ($past(line_req) == $past(line_ack)));

  // R5: acknowledge toggles only against a pending request
  assert_ack_pending_R5: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (line_ack != $past(line_ack)) |-> ($past(line_req) != $past(line_ack)));

  // R7: held byte is kept until taken
  assert_hold_byte_R7: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R8: no acknowledge while the output register is full and not taken
  assert_stall_ack_R8: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(line_ack));

  // R9: sender busy right after acceptance
  assert_busy_after_accept_R9: assert property (@(posedge clk_tx) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind hsl_link hsl_link_chk #(.DATA_W(DATA_W)) chk (
  .clk_tx(clk_tx), .clk_rx(clk_rx), .rst_n(rst_n),
  .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
  .line_data(line_data), .line_req(line_req), .line_ack(line_ack));

// File: tb/hsl_link_test.sv
`timescale 1ns/1ps
module hsl_link_test;
  localparam int W = 8;

  logic clk_tx = 1'b0, clk_rx = 1'b0, rst_n = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic tx_ready, rx_valid, line_data, line_req, line_ack;
  logic [W-1:0] rx_data;

  int checks = 0, fails = 0;
  logic stall = 1'b0;
  logic [W-1:0] expq[$];
  logic bitq[$];
  logic prev_req = 1'b0;

  always #5.0 clk_tx = ~clk_tx;
  always #6.5 clk_rx = ~clk_rx;

  hsl_link #(.DATA_W(W)) uut (
    .clk_tx(clk_tx), .clk_rx(clk_rx), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .line_data(line_data), .line_req(line_req), .line_ack(line_ack));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Driver: offer one byte, push expectations (R2 bits LSB first, R6 bytes)
  task automatic send(input logic [W-1:0] b);
    @(negedge clk_tx);
    while (!tx_ready) @(negedge clk_tx);
    tx_valid = 1'b1;
    tx_data  = b;
    expq.push_back(b);
    for (int i = 0; i < W; i++) bitq.push_back(b[i]);
    @(negedge clk_tx);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R9", {31'd0, tx_ready}, 32'd0);
  endtask

  // Bit monitor on the sending side: one bit per request change (R2)
  always @(negedge clk_tx) begin
    if (rst_n && line_req != prev_req) begin
      if (bitq.size() == 0) begin
        check(1'b0, "R2 unexpected bit", {31'd0, line_data}, 32'd0);
      end else begin
        logic e;
        e = bitq.pop_front();
        check(line_data == e, "R2", {31'd0, line_data}, {31'd0, e});
      end
    end
    prev_req = line_req;
  end

  // Byte monitor with random back-pressure (R6)
  always @(negedge clk_rx) begin
    if (rst_n) begin
      rx_ready = stall ? 1'b0 : (($urandom % 4) != 0);
      if (rx_valid && rx_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R6 unexpected byte", {24'd0, rx_data}, 32'd0);
        end else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(rx_data == e, "R6", {24'd0, rx_data}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    #1_500_000;
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  task automatic drain();
    while (expq.size() != 0) @(negedge clk_rx);
    repeat (10) @(negedge clk_tx);
  endtask

  initial begin
    logic [W-1:0] held;
    logic ack_before;
    int bad;
    repeat (3) @(negedge clk_tx);
    // R1: reset state
    check(tx_ready == 1'b1, "R1 tx_ready", {31'd0, tx_ready}, 32'd1);
    check(rx_valid == 1'b0, "R1 rx_valid", {31'd0, rx_valid}, 32'd0);
    check(line_req == 1'b0 && line_ack == 1'b0, "R1 lines",
          {30'd0, line_req, line_ack}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_tx);
    check(tx_ready == 1'b1 && rx_valid == 1'b0, "R1 after release",
          {30'd0, tx_ready, rx_valid}, 32'd2);

    // Distinct patterns (R2, R6, R9)
    send(8'h00); send(8'hFF); send(8'hA5); send(8'h01); send(8'h80);
    for (int i = 0; i < W; i++) send(8'(1 << i));
    for (int i = 0; i < 30; i++) send(8'($urandom));
    drain();

    // Long receiver stall (R7, R8)
    stall = 1'b1;
    send(8'h3C);
    while (!rx_valid) @(negedge clk_rx);
    held = rx_data;
    check(held == 8'h3C, "R7 held byte", {24'd0, held}, 32'h3C);
    send(8'hC3);
    @(negedge clk_rx);
    ack_before = line_ack;
    bad = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk_rx);
      if (line_ack != ack_before || !rx_valid || rx_data != held || tx_ready) bad++;
    end
    check(bad == 0, "R8 stall", bad, 32'd0);
    check(line_req != line_ack, "R8 bit pending", {30'd0, line_req, line_ack}, 32'd1);
    stall = 1'b0;
    drain();
    check(bitq.size() == 0, "R2 all bits seen", bitq.size(), 32'd0);
    check(tx_ready == 1'b1 && rx_valid == 1'b0, "R6 idle at end",
          {30'd0, tx_ready, rx_valid}, 32'd2);
    finish_run();
  end
endmodule